// File: doc/BRIEF.md
# Accumulator Processor with Microcycle Sequencer

This block is a small stored-program processor built around one 16-bit accumulator. Each 16-bit instruction word carries a 4-bit operation code in its top bits and a 12-bit direct operand address below it, so the processor reaches 4096 words. An external single-port memory is attached through an address, write-data, write-strobe and combinational read-data port.

A three-bit timing counter steps through numbered microcycles. Every register load is a control term formed from one microcycle ANDed with the decoded operation. The first three microcycles fetch the instruction and are the same for every operation. After the last microcycle of an instruction the counter returns to the first one. The accumulator's next value comes from a seven-way selector, and the memory data register's next value from a two-way selector.

A 16-bit value is captured from an input port every cycle. A 16-bit output register drives the output port. A halt flag stops all activity until reset.

Top module: `acc_cpu`

## Requirements
- R1: While and right after reset `rst_n` is low, `out_port` is 0, `halted` is 0 and `mem_addr` is 0. Execution begins with the word at address 0.
- R2: The instruction word holds the operation in bits 15:12 and the operand address in bits 11:0. The operation codes are load=0, store=1, add=2, and=3, complement=4, rotate-left=5, jump=6, jump-if-zero=7, input=8, output=9, halt=10. The program counter advances by one on every fetch. Fetch takes three clock cycles.
- R3: Load (code 0) takes exactly 6 clock cycles and leaves the accumulator equal to the memory word at its address.
- R4: Store (code 1) takes exactly 6 cycles. In its sixth cycle it writes the accumulator to the memory word at its address, with `mem_wdata` equal to the accumulator.
- R5: Add (code 2) and and (code 3) each take 6 cycles. They combine the accumulator with the addressed word: add is the sum modulo 2^16, and is the bitwise AND.
- R6: Complement (code 4) inverts every accumulator bit. Rotate-left (code 5) moves every bit up one place and moves bit 15 into bit 0. Each takes 4 cycles.
- R7: Jump (code 6) always continues at its address. Jump-if-zero (code 7) continues at its address only when the accumulator is 0, and otherwise continues at the next word. Each takes 4 cycles.
- R8: Input (code 8) loads the accumulator with the value `in_port` held in the previous cycle. Output (code 9) copies the accumulator to `out_port`. Each takes 4 cycles.
- R9: Halt (code 10) sets `halted` at the end of its fourth cycle. From then until reset, no register changes, no memory write occurs, and `mem_addr` and `out_port` stay constant.
- R10: Codes 11 to 15 take 4 cycles and change neither the accumulator nor memory.
- R11: `mem_we` is high only in the final cycle of a store, and for exactly one cycle per store.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mem_addr | output | 12 | Memory address |
| mem_wdata | output | 16 | Memory write data |
| mem_we | output | 1 | Memory write strobe |
| mem_rdata | input | 16 | Memory read data, valid in the same cycle as the address |
| in_port | input | 16 | Value captured into the input register every cycle |
| out_port | output | 16 | Output register |
| halted | output | 1 | Halt flag |

## Verification
The bench runs short programs and counts the exact number of clock cycles from reset to halt. A sequencer that ends a memory operation at the fourth microcycle, or a short operation at the sixth, therefore shows up as a wrong count.

Several corner cases are targeted:
- An add that wraps past 0xFFFF, which a design with a carry into a wider accumulator gets wrong.
- A rotate with bit 15 set, which a plain shift gets wrong by losing the bit.
- A jump-if-zero with a non-zero accumulator, which a design that always jumps would take.
- Reserved codes whose address field points at a distinct word, which would leak into the accumulator if they were decoded as loads.

After halt, the bench changes the input port and waits many cycles. A design that keeps sequencing would then move `mem_addr`, write memory or change the output.

// File: rtl/acc_cpu.sv
module acc_cpu #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              mem_we,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic [DATA_W-1:0] in_port,
  output logic [DATA_W-1:0] out_port,
  output logic              halted
);
  localparam int OP_W = DATA_W - ADDR_W;
  localparam logic [OP_W-1:0] OP_LDA = OP_W'(0), OP_STA = OP_W'(1), OP_ADD = OP_W'(2),
    OP_AND = OP_W'(3), OP_CMA = OP_W'(4), OP_CIL = OP_W'(5), OP_JMP = OP_W'(6),
    OP_JZ = OP_W'(7), OP_IN = OP_W'(8), OP_OUT = OP_W'(9), OP_HLT = OP_W'(10);

  typedef enum logic [2:0] {
    AC_HOLD, AC_MDR, AC_SUM, AC_AND, AC_INV, AC_ROT, AC_INR
  } ac_sel_e;

  logic [DATA_W-1:0] ac, mdr, inr, outr;
  logic [ADDR_W-1:0] pc, mar;
  logic [OP_W-1:0]   opc;
  logic              hlt;
  logic [2:0]        tstep;

  logic t1, t2, t3, t4, t5, t6;
  assign t1 = tstep == 3'd1;
  assign t2 = tstep == 3'd2;
  assign t3 = tstep == 3'd3;
  assign t4 = tstep == 3'd4;
  assign t5 = tstep == 3'd5;
  assign t6 = tstep == 3'd6;

  logic mem_op, operand_rd, last_step;
  assign mem_op     = opc == OP_LDA || opc == OP_STA || opc == OP_ADD || opc == OP_AND;
  assign operand_rd = opc == OP_LDA || opc == OP_ADD || opc == OP_AND;
  assign last_step  = t6 || (t4 && !mem_op);

  logic ld_mar_pc, ld_mar_adr, ld_mdr, mdr_from_ac, pc_inc, ld_opc, pc_jump, ld_out, set_hlt;
  assign ld_mar_pc   = t1;
  assign ld_mar_adr  = t4;
  assign ld_mdr      = t2 || (t5 && mem_op);
  assign mdr_from_ac = t5 && opc == OP_STA;
  assign pc_inc      = t2;
  assign ld_opc      = t3;
  assign pc_jump     = t4 && (opc == OP_JMP || (opc == OP_JZ && ac == '0));
  assign ld_out      = t4 && opc == OP_OUT;
  assign set_hlt     = t4 && opc == OP_HLT;

  ac_sel_e ac_sel;
  always_comb begin
    ac_sel = AC_HOLD;
    if (t6 && opc == OP_LDA) ac_sel = AC_MDR;
    if (t6 && opc == OP_ADD) ac_sel = AC_SUM;
    if (t6 && opc == OP_AND) ac_sel = AC_AND;
    if (t4 && opc == OP_CMA) ac_sel = AC_INV;
    if (t4 && opc == OP_CIL) ac_sel = AC_ROT;
    if (t4 && opc == OP_IN)  ac_sel = AC_INR;
  end

  logic [DATA_W-1:0] ac_next;
  always_comb begin
    case (ac_sel)
      AC_MDR:  ac_next = mdr;
      AC_SUM:  ac_next = ac + mdr;
      AC_AND:  ac_next = ac & mdr;
      AC_INV:  ac_next = ~ac;
      AC_ROT:  ac_next = {ac[DATA_W-2:0], ac[DATA_W-1]};
      AC_INR:  ac_next = inr;
      default: ac_next = ac;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ac <= '0; pc <= '0; mar <= '0; mdr <= '0;
      inr <= '0; outr <= '0; opc <= '0; hlt <= 1'b0;
      tstep <= 3'd1;
    end else if (!hlt) begin
      ac    <= ac_next;
      inr   <= in_port;
      tstep <= last_step ? 3'd1 : tstep + 3'd1;
      if (ld_mar_pc)  mar <= pc;
      if (ld_mar_adr) mar <= mdr[ADDR_W-1:0];
      if (ld_mdr)     mdr <= mdr_from_ac ? ac : mem_rdata;
      if (ld_opc)     opc <= mdr[DATA_W-1:ADDR_W];
      if (pc_inc)     pc  <= pc + 1'b1;
      if (pc_jump)    pc  <= mdr[ADDR_W-1:0];
      if (ld_out)     outr <= ac;
      if (set_hlt)    hlt <= 1'b1;
    end
  end

  assign mem_addr  = mar;
  assign mem_wdata = mdr;
  assign mem_we    = !hlt && t6 && opc == OP_STA;
  assign out_port  = outr;
  assign halted    = hlt;
endmodule

// File: rtl/acc_cpu_chk.sv
module acc_cpu_chk #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic [2:0]        tstep,
  input logic [DATA_W-ADDR_W-1:0] opc,
  input logic [ADDR_W-1:0] pc,
  input logic [DATA_W-1:0] ac,
  input logic [DATA_W-1:0] out_port,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_we,
  input logic [DATA_W-1:0] mem_wdata,
  input logic              halted
);
  localparam int OP_W = DATA_W - ADDR_W;

  assert_step_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    tstep >= 3'd1 && tstep <= 3'd6);

  assert_pc_advance_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (tstep == 3'd2 && !halted) |=> pc == $past(pc) + 1'b1);

  assert_store_data_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> mem_wdata == ac);

  assert_rotate_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (tstep == 3'd4 && opc == OP_W'(5) && !halted) |=> ac == {$past(ac[DATA_W-2:0]), $past(ac[DATA_W-1])});

  assert_jz_fallthrough_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (tstep == 3'd4 && opc == OP_W'(7) && ac != '0 && !halted) |=> pc == $past(pc));

  assert_halt_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> halted);

  assert_halt_freeze_R9: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> $stable(pc) && $stable(ac) && $stable(out_port) && $stable(mem_addr) && !mem_we);

  assert_single_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> !mem_we);
endmodule

bind acc_cpu acc_cpu_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tstep(tstep), .opc(opc), .pc(pc), .ac(ac),
  .out_port(out_port), .mem_addr(mem_addr), .mem_we(mem_we),
  .mem_wdata(mem_wdata), .halted(halted)
);

// File: tb/acc_cpu_bench.sv
module acc_cpu_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [11:0] mem_addr;
  logic [15:0] mem_wdata, mem_rdata, in_port, out_port;
  logic mem_we, halted;

  int checks = 0, failures = 0, we_count = 0;
  bit done = 1'b0;

  logic [15:0] mem [0:255];
  logic        ld_en = 1'b0;
  logic [7:0]  ld_a = '0;
  logic [15:0] ld_d = '0;

  always #4 clk = ~clk;

  acc_cpu u_acc_cpu (
    .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_we(mem_we), .mem_rdata(mem_rdata), .in_port(in_port),
    .out_port(out_port), .halted(halted)
  );

  assign mem_rdata = mem[mem_addr[7:0]];

  always @(posedge clk) begin
    if (mem_we) begin
      mem[mem_addr[7:0]] <= mem_wdata;
      we_count <= we_count + 1;
    end else if (ld_en) begin
      mem[ld_a] <= ld_d;
    end
  end

  function automatic logic [15:0] w(input int op, input int adr);
    return {op[3:0], adr[11:0]};
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic put(input int a, input logic [15:0] d);
    @(negedge clk);
    ld_a = a[7:0]; ld_d = d; ld_en = 1'b1;
    @(negedge clk);
    ld_en = 1'b0;
  endtask

  task automatic hold_reset();
    @(negedge clk);
    rst_n = 1'b0;
  endtask

  task automatic run(output int n);
    @(negedge clk);
    rst_n = 1'b1;
    n = 0;
    while (!halted && n < 500) begin
      @(posedge clk);
      n++;
      @(negedge clk);
    end
  endtask

  task automatic t_reset();
    hold_reset();
    @(negedge clk);
    chk(out_port == 16'h0, "R1 out_port", out_port, 0);
    chk(halted == 1'b0, "R1 halted", halted, 0);
    chk(mem_addr == 12'h0, "R1 mem_addr", mem_addr, 0);
    chk(mem_we == 1'b0, "R1 mem_we", mem_we, 0);
  endtask

  task automatic t_load_add();
    int n, base;
    hold_reset();
    put(0, w(0, 20)); put(1, w(2, 21)); put(2, w(9, 0)); put(3, w(10, 0));
    put(20, 16'h1234); put(21, 16'hFFFF);
    base = we_count;
    run(n);
    chk(out_port == 16'h1233, "R5 add wraps", out_port, 16'h1233);
    chk(n == 20, "R3 R2 load/add cycle count", n, 20);
    chk(we_count == base, "R11 no write without store", we_count - base, 0);
  endtask

  task automatic t_store_logic();
    int n, base;
    hold_reset();
    put(0, w(0, 20)); put(1, w(3, 21)); put(2, w(5, 0)); put(3, w(1, 30));
    put(4, w(4, 0)); put(5, w(9, 0)); put(6, w(10, 0));
    put(20, 16'hF0F1); put(21, 16'h8FF0); put(30, 16'h0000);
    base = we_count;
    run(n);
    chk(mem[30] == 16'h01E1, "R4 R6 stored rotate result", mem[30], 16'h01E1);
    chk(out_port == 16'hFE1E, "R6 complement", out_port, 16'hFE1E);
    chk(n == 34, "R4 R6 cycle count", n, 34);
    chk(we_count - base == 1, "R11 one write per store", we_count - base, 1);
  endtask

  task automatic t_jumps();
    int n;
    hold_reset();
    put(0, w(6, 2)); put(1, w(10, 0)); put(2, w(0, 20)); put(3, w(7, 6));
    put(4, w(9, 0)); put(5, w(10, 0)); put(6, w(0, 21)); put(7, w(7, 10));
    put(8, w(9, 0)); put(9, w(10, 0)); put(10, w(10, 0));
    put(20, 16'h0000); put(21, 16'h0005);
    run(n);
    chk(out_port == 16'h0005, "R7 jz taken then not taken", out_port, 5);
    chk(n == 32, "R7 jump cycle count", n, 32);
  endtask

  task automatic t_io();
    int n;
    hold_reset();
    in_port = 16'hBEEF;
    put(0, w(8, 0)); put(1, w(9, 0)); put(2, w(10, 0));
    run(n);
    chk(out_port == 16'hBEEF, "R8 input to output", out_port, 16'hBEEF);
    chk(n == 12, "R8 io cycle count", n, 12);
  endtask

  task automatic t_reserved();
    int n, base;
    hold_reset();
    put(0, w(0, 20)); put(1, 16'hB023); put(2, 16'hF023);
    put(3, w(9, 0)); put(4, w(10, 0));
    put(20, 16'h0042); put(35, 16'h7777);
    base = we_count;
    run(n);
    chk(out_port == 16'h0042, "R10 reserved codes keep AC", out_port, 16'h0042);
    chk(n == 22, "R10 reserved cycle count", n, 22);
    chk(we_count == base, "R10 reserved codes write nothing", we_count - base, 0);
    chk(mem[35] == 16'h7777, "R10 memory untouched", mem[35], 16'h7777);
  endtask

  task automatic t_halt_freeze();
    int n, base;
    logic [15:0] o;
    logic [11:0] a;
    hold_reset();
    in_port = 16'h1111;
    put(0, w(8, 0)); put(1, w(9, 0)); put(2, w(10, 0)); put(3, w(1, 40)); put(4, w(9, 0));
    put(40, 16'h0000);
    run(n);
    o = out_port; a = mem_addr; base = we_count;
    in_port = 16'h2222;
    repeat (40) @(negedge clk);
    chk(halted == 1'b1, "R9 stays halted", halted, 1);
    chk(out_port == o, "R9 out frozen", out_port, o);
    chk(mem_addr == a, "R9 address frozen", mem_addr, a);
    chk(we_count == base && mem[40] == 16'h0, "R9 no write after halt", we_count - base, 0);
    hold_reset();
    @(negedge clk);
    chk(halted == 1'b0 && out_port == 16'h0, "R1 reset clears halt", halted, 0);
  endtask

  initial begin
    in_port = 16'h0;
    t_reset();
    t_load_add();
    t_store_logic();
    t_jumps();
    t_io();
    t_reserved();
    t_halt_freeze();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      done = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule